// File: doc/BRIEF.md
# Two-Wire Bus Connection Controller

This block decides when the backplane segment and the card segment of a two-wire (clock plus data) bus may be joined. It watches the backplane lines for a transaction boundary, either a STOP condition or a timed idle period. Once it sees a boundary and both card-side lines are high, it drives a connect output that gates an external switch model, and it raises a ready flag. The electrical side of the switch is modelled elsewhere: the wired-AND buffering, the offset regulation and the slew behaviour.

The controller stays disconnected while supply lockout is active, and it ignores all bus activity during that time. A low enable input opens the switch. When enable returns high, the controller waits for a fresh boundary. A stuck-bus timeout reported by the recovery logic opens the switch and records a fault. If enable then rises while that fault is recorded, the switch closes on that edge alone, without waiting for a boundary. All bus lines and enable are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `bus_join_ctrl`

## Requirements
- R1: While `uvlo_ok_i` is low, `connect_o` is low, a connection already made opens on the next clock, and backplane STOPs or idle periods cause no connection.
- R2: A STOP is a rising edge of synchronized backplane data while synchronized backplane clock is high. With enable high, lockout released and both card lines high, a STOP closes the connection within SYNC_STAGES+2 clocks of the data line rising, well before any idle period could expire.
- R3: Bus idle is both synchronized backplane lines high for IDLE_CYCLES consecutive clocks while enabled and released. A low on either line restarts the count. When a connection is made by idle, it is made on the clock after the count completes.
- R4: No boundary-driven connection is made unless both synchronized card-side lines are high. Once they go high with a boundary present, the connection follows within SYNC_STAGES+1 clocks.
- R5: `ready_o` equals `connect_o` in every cycle, and both are low in reset.
- R6: A low on `enable_i` opens the connection within SYNC_STAGES+1 clocks.
- R7: The idle count is held at zero while enable is low. After enable rises on an idle bus, the connection appears exactly IDLE_CYCLES+SYNC_STAGES+1 clocks later, and not one clock earlier.
- R8: A rising edge of enable, made while a fault is recorded, forces the connection regardless of bus state, exactly SYNC_STAGES+2 clocks after the edge. The internal edge pulse lasts one clock.
- R9: The recorded fault is cleared by any connection, so a later enable rise without a new fault does not force a connection.
- R10: A high `stuck_fault_i` opens the connection on the next clock and records a fault. After it drops, reconnection follows the normal boundary rules.
- R11: A rising edge of backplane data while backplane clock is low is not a STOP and causes no connection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_sda_i | input | 1 | Backplane data level, asynchronous |
| bp_scl_i | input | 1 | Backplane clock level, asynchronous |
| card_sda_i | input | 1 | Card-side data level, asynchronous |
| card_scl_i | input | 1 | Card-side clock level, asynchronous |
| enable_i | input | 1 | Connection enable, asynchronous |
| uvlo_ok_i | input | 1 | High once supply lockout is released |
| stuck_fault_i | input | 1 | Stuck-bus timeout from the recovery logic |
| connect_o | output | 1 | Closes the external bus switch |
| ready_o | output | 1 | Connection status flag |

## Verification
The bench measures the idle path to the exact clock, both after enable rises and around the STOP path. An off-by-one idle counter, or a counter that keeps running while enable is low, therefore connects one cycle early or immediately. It drives data rising while the clock is low, which a STOP detector that ignores the clock would mistake for a boundary and connect. It covers the forced path with backplane data held low: once directly after a fault, and once more after a normal connection has cleared the fault. A design that does not latch the fault, or never clears it, then fails to connect in the first case or connects wrongly in the second. It also holds card data low over an idle bus, where a design that skips the card check would join anyway.

// File: rtl/bus_join_pkg.sv
// Shared types for the bus connection controller.
package bus_join_pkg;
    // Connection controller states
    typedef enum logic [1:0] {
        ST_LOCKOUT = 2'd0,
        ST_WAIT    = 2'd1,
        ST_JOINED  = 2'd2
    } join_state_t;
endpackage

// File: rtl/bj_sync.sv
// Multi-bit synchronizer: each bit passes through STAGES flops.
// Assumes the inputs are quasi-static single-bit levels; no bus coherency.
module bj_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bj_boundary_det.sv
// Transaction boundary detector on the synchronized backplane lines.
// Flags a STOP (data rising while clock high) or an idle period of
// IDLE_CYCLES clocks with both lines high. Only active while armed.
module bj_boundary_det #(
    parameter int IDLE_CYCLES = 4750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic boundary_o
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYCLES);

    logic          sda_prev;
    logic [CW-1:0] idle_cnt;
    logic          stop_seen;
    logic          idle_done;

    // Remember previous data level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_i;
    end

    // Idle counter: restarts on any low or when disarmed, saturates at limit
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_cnt <= '0;
        else if (!arm_i || !sda_i || !scl_i) idle_cnt <= '0;
        else if (idle_cnt != IDLE_MAX)       idle_cnt <= idle_cnt + 1'b1;
    end

    assign stop_seen  = arm_i && sda_i && !sda_prev && scl_i;
    assign idle_done  = (idle_cnt == IDLE_MAX);
    assign boundary_o = stop_seen || idle_done;
endmodule

// File: rtl/bj_edge_reg.sv
// Registered rising-edge detector; output is a one-clock pulse.
module bj_edge_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_prev;

    // Track the level and register the rising-edge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_prev <= 1'b0;
            rise_o     <= 1'b0;
        end else begin
            level_prev <= level_i;
            rise_o     <= level_i && !level_prev;
        end
    end
endmodule

// File: rtl/bj_join_fsm.sv
// Connection decision state machine. Priority: lockout, fault, enable low,
// forced join after a recorded fault, then boundary-plus-card-high join.
module bj_join_fsm
    import bus_join_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_ok_i,
    input  logic fault_i,
    input  logic en_i,
    input  logic en_rise_i,
    input  logic boundary_i,
    input  logic card_ok_i,
    output logic force_o,
    output logic joined_o
);
    join_state_t state;
    logic        flt_seen;

    assign force_o = en_rise_i && flt_seen;

    // State and fault-record update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_LOCKOUT;
            flt_seen <= 1'b0;
        end else if (!uvlo_ok_i) begin
            state <= ST_LOCKOUT;
        end else if (fault_i) begin
            state    <= ST_WAIT;
            flt_seen <= 1'b1;
        end else if (!en_i) begin
            state <= ST_WAIT;
        end else if (force_o) begin
            state    <= ST_JOINED;
            flt_seen <= 1'b0;
        end else begin
            case (state)
                ST_LOCKOUT: state <= ST_WAIT;
                ST_WAIT: begin
                    if (boundary_i && card_ok_i) begin
                        state    <= ST_JOINED;
                        flt_seen <= 1'b0;
                    end
                end
                default: state <= ST_JOINED;
            endcase
        end
    end

    assign joined_o = (state == ST_JOINED);
endmodule

// File: rtl/bus_join_ctrl.sv
// Top of the two-wire bus connection controller. Synchronizes bus lines
// and enable, detects backplane boundaries, and decides the switch state.
module bus_join_ctrl #(
    parameter int IDLE_CYCLES = 4750,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic card_sda_i,
    input  logic card_scl_i,
    input  logic enable_i,
    input  logic uvlo_ok_i,
    input  logic stuck_fault_i,
    output logic connect_o,
    output logic ready_o
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    logic bp_sda_s, bp_scl_s, card_sda_s, card_scl_s, en_s;
    logic card_ok, boundary, en_rise, force_join, joined;

    assign raw_in = {enable_i, card_scl_i, card_sda_i, bp_scl_i, bp_sda_i};
    assign {en_s, card_scl_s, card_sda_s, bp_scl_s, bp_sda_s} = syn;
    assign card_ok = card_sda_s && card_scl_s;

    bj_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
    );

    bj_boundary_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_det (
        .clk(clk), .rst_n(rst_n), .arm_i(uvlo_ok_i && en_s),
        .sda_i(bp_sda_s), .scl_i(bp_scl_s), .boundary_o(boundary)
    );

    bj_edge_reg u_en_edge (
        .clk(clk), .rst_n(rst_n), .level_i(en_s), .rise_o(en_rise)
    );

    bj_join_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .uvlo_ok_i(uvlo_ok_i),
        .fault_i(stuck_fault_i), .en_i(en_s), .en_rise_i(en_rise),
        .boundary_i(boundary), .card_ok_i(card_ok),
        .force_o(force_join), .joined_o(joined)
    );

    assign connect_o = joined;
    assign ready_o   = joined;
endmodule

// File: rtl/bus_join_ctrl_chk.sv
// Property checker for bus_join_ctrl, attached by bind.
module bus_join_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic uvlo_ok_i,
    input logic stuck_fault_i,
    input logic connect_o,
    input logic ready_o,
    input logic en_sync,
    input logic card_ok,
    input logic boundary,
    input logic en_rise,
    input logic force_join
);
    assert_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok_i |=> !connect_o);

    assert_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_o) |-> ($past(boundary) || $past(force_join)));

    assert_card_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_o) |-> ($past(card_ok) || $past(force_join)));

    assert_ready_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == connect_o);

    assert_enable_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sync |=> !connect_o);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !en_rise);

    assert_fault_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_fault_i |=> !connect_o);
endmodule

bind bus_join_ctrl bus_join_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uvlo_ok_i(uvlo_ok_i),
    .stuck_fault_i(stuck_fault_i), .connect_o(connect_o), .ready_o(ready_o),
    .en_sync(en_s), .card_ok(card_ok), .boundary(boundary),
    .en_rise(en_rise), .force_join(force_join)
);

// File: tb/bus_join_ctrl_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module bus_join_ctrl_test;
    localparam int IDLE = 20;
    localparam int SYNC = 2;
    localparam int NVEC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bsda = 1'b1, bscl = 1'b1, csda = 1'b1, cscl = 1'b1;
    logic en = 1'b1, uvlo = 1'b0, flt = 1'b0;
    logic connect, ready;
    int   n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    bus_join_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .bp_sda_i(bsda), .bp_scl_i(bscl),
        .card_sda_i(csda), .card_scl_i(cscl), .enable_i(en),
        .uvlo_ok_i(uvlo), .stuck_fault_i(flt),
        .connect_o(connect), .ready_o(ready)
    );

    // Vector: [15]bp_sda [14]bp_scl [13]card_sda [12]card_scl [11]en
    //         [10]uvlo [9]fault [8:1]hold clocks [0]expected connect
    localparam logic [15:0] VEC [NVEC] = '{
        {7'b1111100, 8'd30, 1'b0},
        {7'b1111110, 8'd18, 1'b0},
        {7'b1111110, 8'd4,  1'b1},
        {7'b1111010, 8'd4,  1'b0},
        {7'b1101110, 8'd30, 1'b0},
        {7'b1111110, 8'd4,  1'b1},
        {7'b1111010, 8'd4,  1'b0},
        {7'b0111110, 8'd30, 1'b0},
        {7'b0011110, 8'd3,  1'b0},
        {7'b1011110, 8'd4,  1'b0},
        {7'b0011110, 8'd3,  1'b0},
        {7'b0111110, 8'd3,  1'b0},
        {7'b1111110, 8'd4,  1'b1},
        {7'b1111111, 8'd2,  1'b0},
        {7'b1111110, 8'd24, 1'b1},
        {7'b1111100, 8'd2,  1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 15:        return "R1";
            1, 2:         return "R3";
            3, 6:         return "R6";
            4, 5:         return "R4";
            9:            return "R11";
            12:           return "R2";
            default:      return "R10";
        endcase
    endfunction

    task automatic check(input logic exp, input string tag);
        n_run++;
        if (connect !== exp || ready !== connect) begin
            n_fail++;
            $display("FAIL %s: connect=%b ready=%b expected %b", tag, connect, ready, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                step(3);
                check(1'b0, "R5");            // reset state
                rst_n = 1'b1;
                for (int i = 0; i < NVEC; i++) begin
                    {bsda, bscl, csda, cscl, en, uvlo, flt} = VEC[i][15:9];
                    step(int'(VEC[i][8:1]));
                    check(VEC[i][0], vec_tag(i));
                end
                // R1: STOP during lockout is ignored
                bsda = 1'b0; step(5);
                bsda = 1'b1; step(5);
                check(1'b0, "R1");
                // R7 / R3: exact idle latency after enable rises
                uvlo = 1'b1; en = 1'b0; step(5);
                en = 1'b1; step(IDLE + SYNC);
                check(1'b0, "R7");
                step(1);
                check(1'b1, "R7");
                // R10 then R8: forced join with data held low
                bsda = 1'b0; step(3);
                check(1'b1, "R3");
                flt = 1'b1; step(2);
                check(1'b0, "R10");
                flt = 1'b0; en = 1'b0; step(5);
                check(1'b0, "R6");
                en = 1'b1; step(SYNC + 1);
                check(1'b0, "R8");
                step(1);
                check(1'b1, "R8");
                // R9: second enable rise without a new fault does not force
                en = 1'b0; step(5);
                check(1'b0, "R6");
                en = 1'b1; step(10);
                check(1'b0, "R9");
            end
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule